// File: doc/BRIEF.md
# Register-Driven SPI Flash Command Engine

This block is a half-duplex SPI master that performs one complete command transaction each time software asks it to. Software works through a byte-wide synchronous register port. It writes the command opcode, a count of bytes to send, a count of bytes to receive and the outgoing payload into a shared byte buffer. It then picks one of four chip-select lines and sets an execute bit. The engine lowers the chosen chip select and shifts the opcode out, followed by the payload. It then clocks in the requested number of reply bytes and stores them in the buffer directly behind the payload.

A busy flag stays high from the execute request until the chip select is released. Software polls this flag and reads the reply once it is clear. The serial clock follows SPI mode 0: it idles low, data changes on the falling edge and data is sampled on the rising edge. It is derived from the system clock by a fixed even divider.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset every chip-select output is high, `sck` and `mosi` are low, and every register and buffer byte reads 0x00.
- R2: Register reads return data on `reg_rdata` one clock after `reg_rd` is sampled high. Byte 0x00 holds the opcode. Byte 0x48 holds the send count. Byte 0x4B holds the receive count. Byte 0x1D stores all 8 bits written, and its bits [1:0] select the chip select. Bytes 0x01, 0x02 and 0x03 read as zero apart from their control and status bits.
- R3: The buffer has 72 bytes at addresses 0x80 to 0xC7. Reads from 0xC8 to 0xFF return 0x00, and writes there change nothing.
- R4: Writing byte 0x02 with bit 0 set starts a transaction. Bit 0 and the pointer-clear bit (bit 4) read back as 0 one clock later. An execute write made while busy is set starts no further transaction.
- R5: Busy (bit 7 of byte 0x03) is 1 from the clock after the execute write until the chip select has been released, and 0 otherwise.
- R6: During a transaction exactly one line, `cs_n[sel]`, is low. `sel` is taken from byte 0x1D at start, and a later write to 0x1D does not move it.
- R7: `mosi` carries the opcode, then buffer bytes 0 to count-1, most significant bit first. It changes only while `sck` is low. It is held low during the receive bytes.
- R8: Receive byte k is written to buffer position sendcount+k if that position is below 72. Data arriving while the engine is sending is discarded, so buffer bytes 0 to sendcount-1 keep their values.
- R9: A transaction has exactly 8*(1+send+receive) rising `sck` edges. An opcode-only transaction has 8. The chip select stays low for (2*bits+1)*CLK_DIV/2 clocks, where bits is the number of rising `sck` edges.
- R10: `sck` is low whenever no chip select is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| miso | input | 1 | Serial data from the device |
| sck | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data to the device |
| cs_n | output | CS_N | Active-low chip selects |

## Verification
The bench sweeps every combination of 0 to 3 send bytes with 0 to 3 receive bytes across all chip selects, and runs one long transaction that overflows the 72-byte buffer. A design that placed reply bytes at position 0 instead of at the send count would overwrite the payload and fail the payload-intact check. A wrong frame length would show up as a rising-edge count that differs from 8 per byte. Some transactions write a second execute request and move the chip-select register mid-frame. A design that re-triggered or re-latched would show two frames or a wrong line going low. Replies that run past the buffer must be dropped: the last in-range byte must hold the right value and nothing may wrap onto position 0.

// File: rtl/spi_cmd_pkg.sv
`timescale 1ns/1ps
package spi_cmd_pkg;
  localparam int SLOT_W = 9;

  localparam logic [7:0] A_OPCODE = 8'h00;
  localparam logic [7:0] A_CTRL1  = 8'h01;
  localparam logic [7:0] A_CMD    = 8'h02;
  localparam logic [7:0] A_STAT   = 8'h03;
  localparam logic [7:0] A_CSSEL  = 8'h1D;
  localparam logic [7:0] A_TXCNT  = 8'h48;
  localparam logic [7:0] A_RXCNT  = 8'h4B;
  localparam logic [7:0] A_BUF    = 8'h80;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_TAIL} eng_state_t;

  // Index of the last byte in a frame (opcode is byte 0).
  function automatic logic [SLOT_W-1:0] last_byte(input logic [7:0] tx, input logic [7:0] rx);
    return SLOT_W'(tx) + SLOT_W'(rx);
  endfunction

  // Buffer slot that backs frame byte b (b >= 1).
  function automatic logic [SLOT_W-1:0] slot_of(input logic [SLOT_W-1:0] b);
    return b - SLOT_W'(1);
  endfunction

  // True when frame byte b is a receive byte.
  function automatic logic is_rx_byte(input logic [SLOT_W-1:0] b, input logic [7:0] tx);
    return b > SLOT_W'(tx);
  endfunction
endpackage

// File: rtl/spi_cmd_halfdiv.sv
`timescale 1ns/1ps
module spi_cmd_halfdiv #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(HALF + 1);
  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/spi_cmd_regs.sv
`timescale 1ns/1ps
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int FIFO_DEPTH = 72,
  parameter int CS_N = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  input  logic [7:0]                 reg_addr,
  input  logic [7:0]                 reg_wdata,
  output logic [7:0]                 reg_rdata,
  input  logic                       busy_i,
  input  logic                       eng_we,
  input  logic [SLOT_W-1:0]          eng_waddr,
  input  logic [7:0]                 eng_wdata,
  input  logic [SLOT_W-1:0]          eng_raddr,
  output logic [7:0]                 eng_rdata,
  output logic [7:0]                 opcode,
  output logic [7:0]                 tx_cnt,
  output logic [7:0]                 rx_cnt,
  output logic [$clog2(CS_N)-1:0]    cs_sel,
  output logic                       exec_pulse
);
  localparam int AW = $clog2(FIFO_DEPTH);

  logic [7:0] mem [FIFO_DEPTH];
  logic [7:0] op_q, tx_q, rx_q, cs_q;
  logic       exec_q, fclr_q;
  logic [7:0] rd_mux;
  logic [7:0] sw_off;
  logic       sw_in_buf;

  assign sw_off    = reg_addr - A_BUF;
  assign sw_in_buf = (reg_addr >= A_BUF) && (32'(sw_off) < FIFO_DEPTH);

  assign opcode     = op_q;
  assign tx_cnt     = tx_q;
  assign rx_cnt     = rx_q;
  assign cs_sel     = cs_q[$clog2(CS_N)-1:0];
  assign exec_pulse = exec_q;
  assign eng_rdata  = (32'(eng_raddr) < FIFO_DEPTH) ? mem[eng_raddr[AW-1:0]] : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= '0; tx_q <= '0; rx_q <= '0; cs_q <= '0;
      exec_q <= 1'b0; fclr_q <= 1'b0;
    end else begin
      exec_q <= reg_wr && (reg_addr == A_CMD) && reg_wdata[0] && !busy_i;
      fclr_q <= reg_wr && (reg_addr == A_CMD) && reg_wdata[4];
      if (reg_wr) begin
        case (reg_addr)
          A_OPCODE: op_q <= reg_wdata;
          A_TXCNT:  tx_q <= reg_wdata;
          A_RXCNT:  rx_q <= reg_wdata;
          A_CSSEL:  cs_q <= reg_wdata;
          default:  ;
        endcase
      end
    end
  end

  // Buffer storage; the engine write wins over a same-cycle software write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < FIFO_DEPTH; i++) mem[i] <= '0;
    end else if (eng_we) begin
      if (32'(eng_waddr) < FIFO_DEPTH) mem[eng_waddr[AW-1:0]] <= eng_wdata;
    end else if (reg_wr && sw_in_buf) begin
      mem[sw_off[AW-1:0]] <= reg_wdata;
    end
  end

  always_comb begin
    case (reg_addr)
      A_OPCODE: rd_mux = op_q;
      A_CTRL1:  rd_mux = 8'h00;
      A_CMD:    rd_mux = {3'b000, fclr_q, 3'b000, exec_q};
      A_STAT:   rd_mux = {busy_i, 7'b0};
      A_CSSEL:  rd_mux = cs_q;
      A_TXCNT:  rd_mux = tx_q;
      A_RXCNT:  rd_mux = rx_q;
      default:  rd_mux = sw_in_buf ? mem[sw_off[AW-1:0]] : 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/spi_cmd_sequencer.sv
`timescale 1ns/1ps
module spi_cmd_sequencer
  import spi_cmd_pkg::*;
#(
  parameter int CS_N = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic                     start,
  input  logic [7:0]               opcode,
  input  logic [7:0]               tx_cnt,
  input  logic [7:0]               rx_cnt,
  input  logic [$clog2(CS_N)-1:0]  cs_sel,
  input  logic                     miso,
  input  logic [7:0]               fifo_rdata,
  output logic [SLOT_W-1:0]        fifo_raddr,
  output logic                     fifo_we,
  output logic [SLOT_W-1:0]        fifo_waddr,
  output logic [7:0]               fifo_wdata,
  output logic                     run,
  output logic                     sck,
  output logic                     mosi,
  output logic [CS_N-1:0]          cs_n
);
  eng_state_t        st_q;
  logic [7:0]        txsh_q, rxsh_q, tx_l;
  logic [2:0]        bit_q;
  logic [SLOT_W-1:0] bidx_q, last_q, nidx;
  logic              sck_q, mosi_q;
  logic [CS_N-1:0]   cs_q;
  logic              fall_ev, rise_ev, byte_end;
  logic [7:0]        next_byte;

  assign run      = (st_q != ST_IDLE);
  assign rise_ev  = (st_q == ST_RUN) && tick && !sck_q;
  assign fall_ev  = (st_q == ST_RUN) && tick && sck_q;
  assign byte_end = fall_ev && (bit_q == 3'd7);
  assign nidx     = bidx_q + SLOT_W'(1);

  assign fifo_raddr = slot_of(nidx);
  assign next_byte  = is_rx_byte(nidx, tx_l) ? 8'h00 : fifo_rdata;
  assign fifo_we    = byte_end && is_rx_byte(bidx_q, tx_l);
  assign fifo_waddr = slot_of(bidx_q);
  assign fifo_wdata = rxsh_q;

  assign sck  = sck_q;
  assign mosi = mosi_q;
  assign cs_n = cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; txsh_q <= '0; rxsh_q <= '0; tx_l <= '0;
      bit_q <= '0; bidx_q <= '0; last_q <= '0;
      sck_q <= 1'b0; mosi_q <= 1'b0; cs_q <= '1;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          st_q   <= ST_RUN;
          tx_l   <= tx_cnt;
          last_q <= last_byte(tx_cnt, rx_cnt);
          bidx_q <= '0;
          bit_q  <= '0;
          txsh_q <= opcode;
          mosi_q <= opcode[7];
          sck_q  <= 1'b0;
          cs_q   <= ~(CS_N'(1) << cs_sel);
        end
        ST_RUN: begin
          if (rise_ev) begin
            sck_q  <= 1'b1;
            rxsh_q <= {rxsh_q[6:0], miso};
          end else if (fall_ev) begin
            sck_q <= 1'b0;
            if (bit_q != 3'd7) begin
              bit_q  <= bit_q + 3'd1;
              txsh_q <= {txsh_q[6:0], 1'b0};
              mosi_q <= txsh_q[6];
            end else begin
              bit_q <= '0;
              if (bidx_q == last_q) begin
                st_q   <= ST_TAIL;
                mosi_q <= 1'b0;
              end else begin
                bidx_q <= nidx;
                txsh_q <= next_byte;
                mosi_q <= next_byte[7];
              end
            end
          end
        end
        ST_TAIL: if (tick) begin
          st_q <= ST_IDLE;
          cs_q <= '1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_engine.sv
`timescale 1ns/1ps
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int FIFO_DEPTH = 72,
  parameter int CS_N       = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [7:0]      reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic            miso,
  output logic            sck,
  output logic            mosi,
  output logic [CS_N-1:0] cs_n
);
  localparam int HALF = CLK_DIV / 2;

  logic                    exec_pulse_w, busy_w, run_w, tick_w;
  logic                    eng_we_w;
  logic [SLOT_W-1:0]       eng_waddr_w, eng_raddr_w;
  logic [7:0]              eng_wdata_w, eng_rdata_w;
  logic [7:0]              opcode_w, tx_w, rx_w;
  logic [$clog2(CS_N)-1:0] sel_w;

  assign busy_w = exec_pulse_w | run_w;

  spi_cmd_regs #(.FIFO_DEPTH(FIFO_DEPTH), .CS_N(CS_N)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy_i(busy_w), .eng_we(eng_we_w), .eng_waddr(eng_waddr_w),
    .eng_wdata(eng_wdata_w), .eng_raddr(eng_raddr_w), .eng_rdata(eng_rdata_w),
    .opcode(opcode_w), .tx_cnt(tx_w), .rx_cnt(rx_w), .cs_sel(sel_w),
    .exec_pulse(exec_pulse_w)
  );

  spi_cmd_halfdiv #(.HALF(HALF)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run_w), .tick(tick_w)
  );

  spi_cmd_sequencer #(.CS_N(CS_N)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .start(exec_pulse_w),
    .opcode(opcode_w), .tx_cnt(tx_w), .rx_cnt(rx_w), .cs_sel(sel_w),
    .miso(miso), .fifo_rdata(eng_rdata_w), .fifo_raddr(eng_raddr_w),
    .fifo_we(eng_we_w), .fifo_waddr(eng_waddr_w), .fifo_wdata(eng_wdata_w),
    .run(run_w), .sck(sck), .mosi(mosi), .cs_n(cs_n)
  );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
`timescale 1ns/1ps
module spi_cmd_engine_chk #(
  parameter int CS_N = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [CS_N-1:0] cs_n,
  input logic            sck,
  input logic            mosi,
  input logic            busy,
  input logic            exec_bit,
  input logic            eng_we
);
  a_r6_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  a_r5_busy_covers_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !(&cs_n) |-> busy);

  a_r10_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |-> !sck);

  a_r7_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(mosi));

  a_r4_exec_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    exec_bit |=> !exec_bit);

  a_r8_store_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |-> !(&cs_n));
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.CS_N(CS_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
  .busy(busy_w), .exec_bit(exec_pulse_w), .eng_we(eng_we_w)
);

// File: tb/spi_cmd_engine_bench.sv
`timescale 1ns/1ps
module spi_cmd_engine_bench;
  localparam int DIV = 4;
  localparam int DEPTH = 72;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_addr = '0, reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic miso = 1'b0;
  logic sck, mosi;
  logic [3:0] cs_n;

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  spi_cmd_engine #(.CLK_DIV(DIV), .FIFO_DEPTH(DEPTH), .CS_N(4)) u_spi_cmd_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .miso(miso), .sck(sck), .mosi(mosi), .cs_n(cs_n)
  );

  // ---------------- device model ----------------
  wire all_hi = &cs_n;
  int rseed = 0;
  int rises = 0, frames = 0, cs_clks = 0;
  bit in_frame = 1'b0, prev_act = 1'b0;
  logic [3:0] cs_seen = '1;
  logic [7:0] cap_sh = '0;
  logic [7:0] mb [128];

  function automatic logic [7:0] resp(input int k);
    return 8'(k * 29 + rseed) ^ 8'h5A;
  endfunction

  function automatic logic [7:0] txb(input int i, input int seed);
    return 8'(i * 13 + seed) ^ 8'h33;
  endfunction

  always @(negedge all_hi or posedge all_hi or posedge sck or negedge sck) begin
    if (all_hi) in_frame = 1'b0;
    else if (!in_frame) begin
      in_frame = 1'b1; frames++; rises = 0; cs_seen = cs_n;
      miso = resp(0)[7];
    end else if (sck) begin
      cap_sh = {cap_sh[6:0], mosi};
      rises++;
      if (rises % 8 == 0 && rises / 8 <= 128) mb[rises / 8 - 1] = cap_sh;
    end else begin
      miso = resp(rises / 8)[7 - (rises % 8)];
    end
  end

  always @(negedge clk) begin
    if (!all_hi) begin
      if (!prev_act) cs_clks = 0;
      cs_clks++;
    end
    prev_act = !all_hi;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic run_xact(input logic [7:0] op, input int tx, input int rx,
                          input int sel, input int seed, input bit dbl);
    logic [7:0] d;
    int f0, nby, guard;
    bit ok;
    rseed = seed;
    nby = 1 + tx + rx;
    wr(8'h00, op); wr(8'h48, 8'(tx)); wr(8'h4B, 8'(rx)); wr(8'h1D, 8'hA8 | 8'(sel));
    for (int i = 0; i < tx && i < DEPTH; i++) wr(8'(8'h80 + i), txb(i, seed));
    f0 = frames;
    wr(8'h02, 8'h11);
    rd(8'h03, d); chk(d[7], "R5 busy after exec", d, 8'h80);
    rd(8'h02, d); chk(d == 8'h00, "R4 exec/clear self-clear", d, 0);
    if (dbl) begin
      wr(8'h02, 8'h01);
      wr(8'h1D, 8'(sel ^ 1));
    end
    guard = 0;
    do begin rd(8'h03, d); guard++; end while (d[7] && guard < 20000);
    chk(all_hi, "R5 busy clear only after cs release", cs_n, 4'hF);
    repeat (4 * DIV) @(negedge clk);
    chk(frames == f0 + 1, "R4 one frame per exec", frames - f0, 1);
    chk(rises == 8 * nby, "R9 sck rising edges", rises, 8 * nby);
    chk(cs_clks == (16 * nby + 1) * (DIV / 2), "R9 cs low duration", cs_clks, (16 * nby + 1) * (DIV / 2));
    chk(cs_seen == ~(4'b1 << sel), "R6 chip select line", cs_seen, ~(4'b1 << sel) & 4'hF);
    chk(mb[0] == op, "R7 opcode byte", mb[0], op);
    ok = 1'b1;
    for (int i = 0; i < tx; i++) if (mb[1 + i] != txb(i, seed)) ok = 1'b0;
    chk(ok, "R7 payload bytes", tx, tx);
    ok = 1'b1;
    for (int k = 0; k < rx; k++) if (1 + tx + k < 128 && mb[1 + tx + k] != 8'h00) ok = 1'b0;
    chk(ok, "R7 mosi low while receiving", rx, rx);
    ok = 1'b1;
    for (int k = 0; k < rx && tx + k < DEPTH; k++) begin
      rd(8'(8'h80 + tx + k), d);
      if (d != resp(1 + tx + k)) begin
        ok = 1'b0;
        $display("FAIL R8 reply slot %0d actual=%0h expected=%0h", tx + k, d, resp(1 + tx + k));
      end
    end
    chk(ok, "R8 reply stored at send-count offset", rx, rx);
    ok = 1'b1;
    for (int i = 0; i < tx && i < DEPTH; i++) begin
      rd(8'(8'h80 + i), d);
      if (d != txb(i, seed)) ok = 1'b0;
    end
    chk(ok, "R8 payload area untouched", tx, tx);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // ---------------- main ----------------
  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n == 4'hF, "R1 cs_n at reset", cs_n, 4'hF);
    chk(!sck && !mosi, "R1 sck/mosi at reset", {sck, mosi}, 0);
    rst_n = 1'b1;
    rd(8'h00, d); chk(d == 0, "R1 opcode reset", d, 0);
    rd(8'h48, d); chk(d == 0, "R1 send count reset", d, 0);
    rd(8'h1D, d); chk(d == 0, "R1 select reset", d, 0);
    rd(8'h03, d); chk(d == 0, "R1 status reset", d, 0);
    rd(8'h80, d); chk(d == 0, "R1 buffer reset", d, 0);

    // R2 register map
    wr(8'h1D, 8'hA6); rd(8'h1D, d); chk(d == 8'hA6, "R2 select byte keeps all bits", d, 8'hA6);
    wr(8'h4B, 8'h5C); rd(8'h4B, d); chk(d == 8'h5C, "R2 receive count", d, 8'h5C);
    wr(8'h01, 8'hFF); rd(8'h01, d); chk(d == 0, "R2 unused control byte", d, 0);
    wr(8'h00, 8'h9E); rd(8'h00, d); chk(d == 8'h9E, "R2 opcode", d, 8'h9E);

    // R3 buffer range
    wr(8'hC7, 8'h3C); rd(8'hC7, d); chk(d == 8'h3C, "R3 last buffer byte", d, 8'h3C);
    wr(8'hC8, 8'h77); rd(8'hC8, d); chk(d == 0, "R3 beyond buffer", d, 0);
    rd(8'hFF, d); chk(d == 0, "R3 top address", d, 0);
    rd(8'hC7, d); chk(d == 8'h3C, "R3 out-of-range write no alias", d, 8'h3C);

    // R4..R10 sweep of small frames (opcode-only case included: tx=0, rx=0)
    for (int t = 0; t < 4; t++)
      for (int r = 0; r < 4; r++)
        run_xact(8'(8'h03 + t * 16 + r), t, r, (t + r) % 4, t * 7 + r, t == r);

    // R8 overflow: replies past slot 71 dropped
    run_xact(8'h9F, 60, 20, 2, 91, 1'b1);
    rd(8'hC8, d); chk(d == 0, "R3 beyond buffer after overflow", d, 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule